// File: doc/BRIEF.md
# Local Interrupt Controller State and Enable Registers

This block keeps the control and state registers of one processor's local interrupt controller, and decides what happens to them across four events: a power-up reset, an INIT reset, a hardware global disable and a software disable. A 64-bit base/enable register is written and read through a separate register port. It holds the global enable, a bootstrap-processor flag and the 4 KB-aligned base of the register window. The window registers sit behind a simple memory-mapped read/write port. An access is claimed only when it falls inside the current window and the controller is globally enabled.

Prioritisation, delivery, messaging, timer counting and bus arbitration live in neighbouring blocks. The pending, in-service and trigger-mode words, the command register and the timer counts are only stored and cleared here. The neighbours read the effective enable, the per-source masks, the ID, the arbitration ID and the task priority straight from the output pins.

Top module: `intc_state_regs`

## Requirements
- R1: After power-up reset (`rst_n` low at a clock edge) the base/enable register reads the base field 0xFEE00 in bits 35:12, so the window starts at 0xFEE00000. It reads the global enable as 1 in bit 11 and the `bsp_strap` value in bit 8, and every other bit reads as 0.
- R2: After power-up reset the window registers read as follows, at byte offsets within the window. TPR (0x080), LDR (0x0D0), ICR low (0x300) and high (0x310), timer initial (0x380) and current (0x390) count, divide configuration (0x3E0), and all in-service (0x100+16k), trigger-mode (0x180+16k) and pending (0x200+16k) words read 0. DFR (0x0E0) reads 0xFFFFFFFF. SVR (0x0F0) reads 0x000000FF, with its bit 8 as software enable. Each LVT entry i (0x320+16i) reads 0x00010000, with bit 16 as its mask.
- R3: The ID is latched from `hw_id_strap` at power-up reset. It reads at offset 0x020 in bits 31:24, and the same value appears on `apic_id` and `arb_id`.
- R4: With ID_W=4 only ID bits 27:24 are writable; bits 31:28 ignore writes and read 0.
- R5: An access is claimed (`mm_hit`=1) only when address bits 35:12 equal the base field, address bits 3:0 are 0 and the global enable is 1. Writing a new base field moves the window. Unclaimed reads return 0 and unclaimed writes change nothing.
- R6: Writes to the base/enable register cannot change bit 8, and the reserved bits 7:0, 9, 10 and 63:36 always read 0.
- R7: Clearing bit 11 returns every window register except the ID to its R2 value and keeps it there. No access is claimed while bit 11 is 0. Setting bit 11 again re-enables the controller without a reset.
- R8: A cycle with `init_req` high returns every window register to its R2 value. The ID, `arb_id` and the base/enable register keep their values.
- R9: `ctl_enable` is 1 exactly when the global enable and SVR bit 8 are both 1. Writing SVR bit 8 to 1 enables at any time.
- R10: While SVR bit 8 is 0, every LVT mask bit reads 1 and `lvt_mask` is all ones. A write that clears a mask leaves it at 1, but still updates the entry's other bits.
- R11: Clearing SVR bit 8 leaves the pending and in-service words and the other window registers unchanged.
- R12: The version register (offset 0x030) always reads the VERSION parameter; writes and every kind of reset leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| init_req | input | 1 | INIT reset request, one cycle per request |
| hw_id_strap | input | ID_W | Hardware ID, latched at power-up reset |
| bsp_strap | input | 1 | Bootstrap-processor strap, latched at power-up reset |
| msr_wr_en | input | 1 | Write strobe for the base/enable register |
| msr_wr_data | input | 64 | Base/enable write data |
| msr_rd_data | output | 64 | Base/enable register value |
| mm_valid | input | 1 | Window access valid |
| mm_write | input | 1 | 1 = write, 0 = read |
| mm_addr | input | PADDR_W | Physical byte address |
| mm_wdata | input | 32 | Write data |
| mm_rdata | output | 32 | Read data, 0 when not claimed |
| mm_hit | output | 1 | Access claimed by this block |
| ctl_enable | output | 1 | Effective enable (global and software) |
| global_en | output | 1 | Global enable bit |
| lvt_mask | output | N_LVT | Mask bit of each local source |
| apic_id | output | ID_W | Current ID |
| arb_id | output | ID_W | Arbitration ID |
| tpr_level | output | 8 | Task priority |

## Verification
The bench builds the block with ID_W=4 and leaves the rest at their defaults: PADDR_W=36, N_LVT=6, N_VEC=256, VERSION=0x00060014. The narrow ID brings the masking of ID bits 31:28 within reach. The 36-bit address lets the window move to a base far from its reset value, so the bench can show that the old window no longer answers. Six LVT entries and eight pending words put the mask lock on the first entry and the last entry, and put a pending word in the middle of its bank.

// File: rtl/intc_state_pkg.sv
// Package: shared constants and the window access type for the local
// interrupt controller state registers.
// Assumes: window offsets are decoded at 16-byte granularity (addr[11:4]).
package intc_state_pkg;

    localparam int WORD_W        = 32;
    localparam int LVT_W         = 17;
    localparam int LVT_MASK_BIT  = 16;
    localparam int SVR_W         = 9;
    localparam int SVR_EN_BIT    = 8;
    localparam int MSR_BSP_BIT   = 8;
    localparam int MSR_GEN_BIT   = 11;
    localparam int MSR_BASE_LSB  = 12;

    localparam logic [SVR_W-1:0] SVR_RESET = 9'h0FF;
    localparam logic [LVT_W-1:0] LVT_RESET = 17'h10000;

    // Window slot indices (byte offset >> 4)
    localparam logic [7:0] SLOT_ID    = 8'h02;
    localparam logic [7:0] SLOT_VER   = 8'h03;
    localparam logic [7:0] SLOT_TPR   = 8'h08;
    localparam logic [7:0] SLOT_LDR   = 8'h0D;
    localparam logic [7:0] SLOT_DFR   = 8'h0E;
    localparam logic [7:0] SLOT_SVR   = 8'h0F;
    localparam logic [7:0] SLOT_ISR0  = 8'h10;
    localparam logic [7:0] SLOT_TMR0  = 8'h18;
    localparam logic [7:0] SLOT_IRR0  = 8'h20;
    localparam logic [7:0] SLOT_ICRL  = 8'h30;
    localparam logic [7:0] SLOT_ICRH  = 8'h31;
    localparam logic [7:0] SLOT_LVT0  = 8'h32;
    localparam logic [7:0] SLOT_TINIT = 8'h38;
    localparam logic [7:0] SLOT_TCUR  = 8'h39;
    localparam logic [7:0] SLOT_DIV   = 8'h3E;

    // One claimed window access, as seen by the register banks
    typedef struct packed {
        logic              wr;
        logic [7:0]        idx;
        logic [WORD_W-1:0] data;
    } win_acc_t;

    // True when the access is a claimed write to the given slot
    function automatic logic slot_wr(input win_acc_t a, input logic [7:0] slot);
        return a.wr && (a.idx == slot);
    endfunction

endpackage

// File: rtl/intc_base_msr.sv
// Module: base/enable register. Holds the global enable, the bootstrap
// flag (strap, read-only) and the relocatable window base.
// Assumes: PADDR_W < 64; INIT does not touch this register.
module intc_base_msr
    import intc_state_pkg::*;
#(
    parameter int          PADDR_W   = 36,
    parameter logic [63:0] RESET_BASE = 64'h0000_0000_FEE0_0000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bsp_strap,
    input  logic                      msr_wr_en,
    input  logic [63:0]               msr_wr_data,
    output logic                      global_en,
    output logic [PADDR_W-13:0]       base_q,
    output logic                      gdis_event,
    output logic [63:0]               msr_rd_data
);
    localparam int BASE_W = PADDR_W - MSR_BASE_LSB;
    localparam logic [BASE_W-1:0] BASE_INIT = RESET_BASE[PADDR_W-1:MSR_BASE_LSB];

    logic bsp_q;
    logic unused_rsvd;

    // Register update: strap and reset values at power-up, software writes otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            global_en <= 1'b1;
            base_q    <= BASE_INIT;
            bsp_q     <= bsp_strap;
        end else if (msr_wr_en) begin
            global_en <= msr_wr_data[MSR_GEN_BIT];
            base_q    <= msr_wr_data[PADDR_W-1:MSR_BASE_LSB];
        end
    end

    // Readback image: reserved bits are zero
    always_comb begin
        msr_rd_data                              = '0;
        msr_rd_data[MSR_BSP_BIT]                 = bsp_q;
        msr_rd_data[MSR_GEN_BIT]                 = global_en;
        msr_rd_data[PADDR_W-1:MSR_BASE_LSB]      = base_q;
    end

    // A write that clears the global enable wipes the window this cycle
    assign gdis_event  = msr_wr_en & ~msr_wr_data[MSR_GEN_BIT];
    assign unused_rsvd = ^{msr_wr_data[63:PADDR_W], msr_wr_data[MSR_GEN_BIT-1:0]};

endmodule

// File: rtl/intc_win_decode.sv
// Module: window decoder. Claims an access that falls in the 4 KB window
// at the current base, is 16-byte aligned and arrives while globally enabled.
// Assumes: combinational; the caller registers nothing here.
module intc_win_decode
    import intc_state_pkg::*;
#(
    parameter int PADDR_W = 36
) (
    input  logic                 mm_valid,
    input  logic                 mm_write,
    input  logic [PADDR_W-1:0]   mm_addr,
    input  logic [WORD_W-1:0]    mm_wdata,
    input  logic                 global_en,
    input  logic [PADDR_W-13:0]  base_q,
    output logic                 mm_hit,
    output win_acc_t             acc
);
    // Claim decision and access packaging
    always_comb begin
        mm_hit   = mm_valid && global_en && (mm_addr[3:0] == 4'h0)
                && (mm_addr[PADDR_W-1:12] == base_q);
        acc.wr   = mm_hit && mm_write;
        acc.idx  = mm_addr[11:4];
        acc.data = mm_wdata;
    end

endmodule

// File: rtl/intc_vec_bank.sv
// Module: bank of WORDS 32-bit storage words (pending, in-service or
// trigger-mode). Only stored, written through the window and cleared.
// Assumes: WORDS <= 8 so the bank fits its 0x80-byte slot range.
module intc_vec_bank
    import intc_state_pkg::*;
#(
    parameter int         WORDS     = 8,
    parameter logic [7:0] SLOT_BASE = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe,
    input  win_acc_t          acc,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0]       rd_part [WORDS];
    logic [WORDS-1:0]        wr_sel;
    logic [WORDS*WORD_W-1:0] flat;

    for (genvar k = 0; k < WORDS; k++) begin : g_word
        localparam logic [7:0] MY_SLOT = 8'(SLOT_BASE + k);
        logic [WORD_W-1:0] word_q;

        // Storage word: cleared by any reset flavour, loaded by a claimed write
        always_ff @(posedge clk) begin
            if (!rst_n || wipe)      word_q <= '0;
            else if (wr_sel[k])      word_q <= acc.data;
        end

        assign wr_sel[k]              = slot_wr(acc, MY_SLOT);
        assign rd_part[k]             = (acc.idx == MY_SLOT) ? word_q : '0;
        assign flat[k*WORD_W +: WORD_W] = word_q;
    end

    // Read merge across the bank
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < WORDS; k++) rd_data |= rd_part[k];
    end

    // R11: without a write or a wipe, stored words never change
    a_r11_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wipe && (wr_sel == '0)) |=> $stable(flat));

endmodule

// File: rtl/intc_lvt_bank.sv
// Module: local vector table entries with mask bits. While the software
// enable is (about to be) off, every mask is forced and locked to 1.
// Assumes: N_LVT <= 6 so entries end before the timer slots.
module intc_lvt_bank
    import intc_state_pkg::*;
#(
    parameter int N_LVT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe,
    input  logic              force_mask,
    input  win_acc_t          acc,
    output logic [N_LVT-1:0]  lvt_mask,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] rd_part [N_LVT];
    logic              unused_hi;

    for (genvar i = 0; i < N_LVT; i++) begin : g_ent
        localparam logic [7:0] MY_SLOT = 8'(SLOT_LVT0 + i);
        logic [LVT_W-1:0] ent_q;

        // Entry update: reset to masked, writes cannot unmask while forced
        always_ff @(posedge clk) begin
            if (!rst_n || wipe)
                ent_q <= LVT_RESET;
            else if (slot_wr(acc, MY_SLOT))
                ent_q <= {acc.data[LVT_MASK_BIT] | force_mask, acc.data[LVT_MASK_BIT-1:0]};
            else if (force_mask)
                ent_q[LVT_MASK_BIT] <= 1'b1;
        end

        assign lvt_mask[i] = ent_q[LVT_MASK_BIT];
        assign rd_part[i]  = (acc.idx == MY_SLOT) ? {{(WORD_W-LVT_W){1'b0}}, ent_q} : '0;
    end

    // Read merge across the entries
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_LVT; i++) rd_data |= rd_part[i];
    end

    assign unused_hi = ^acc.data[WORD_W-1:LVT_W];

    // R10: a forced cycle leaves every mask set
    a_r10_masks_locked: assert property (@(posedge clk) disable iff (!rst_n)
        force_mask |=> (&lvt_mask));

endmodule

// File: rtl/intc_state_regs.sv
// Module: top of the local interrupt controller state registers. Owns the
// ID, priority, format, spurious-vector, command, timer-setup registers,
// combines the reset flavours into one wipe, and builds the read mux.
// Assumes: ID_W is 4 or 8; N_VEC is a multiple of 32 and at most 256.
module intc_state_regs
    import intc_state_pkg::*;
#(
    parameter int          PADDR_W    = 36,
    parameter int          ID_W       = 8,
    parameter int          N_LVT      = 6,
    parameter int          N_VEC      = 256,
    parameter logic [31:0] VERSION    = 32'h0006_0014,
    parameter logic [63:0] RESET_BASE = 64'h0000_0000_FEE0_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init_req,
    input  logic [ID_W-1:0]     hw_id_strap,
    input  logic                bsp_strap,
    input  logic                msr_wr_en,
    input  logic [63:0]         msr_wr_data,
    output logic [63:0]         msr_rd_data,
    input  logic                mm_valid,
    input  logic                mm_write,
    input  logic [PADDR_W-1:0]  mm_addr,
    input  logic [31:0]         mm_wdata,
    output logic [31:0]         mm_rdata,
    output logic                mm_hit,
    output logic                ctl_enable,
    output logic                global_en,
    output logic [N_LVT-1:0]    lvt_mask,
    output logic [ID_W-1:0]     apic_id,
    output logic [ID_W-1:0]     arb_id,
    output logic [7:0]          tpr_level
);
    localparam int PEND_WORDS = N_VEC / WORD_W;
    localparam int N_BANKS    = 3;
    localparam int ID_LSB     = 24;
    localparam logic [7:0] BANK_SLOT [N_BANKS] = '{SLOT_ISR0, SLOT_TMR0, SLOT_IRR0};

    logic [PADDR_W-13:0] base_q;
    logic                gdis_event;
    logic                wipe;
    win_acc_t            acc;

    logic [ID_W-1:0]     id_q, arb_q;
    logic [7:0]          tpr_q, ldr_q, icr_hi_q;
    logic [31:0]         dfr_q, icr_lo_q, tinit_q, tcur_q;
    logic [3:0]          div_q;
    logic [SVR_W-1:0]    svr_q, svr_d;
    logic                id_wr;

    logic [WORD_W-1:0]   lvt_rd;
    logic [WORD_W-1:0]   bank_rd [N_BANKS];
    logic [WORD_W-1:0]   rd_word;

    intc_base_msr #(
        .PADDR_W   (PADDR_W),
        .RESET_BASE(RESET_BASE)
    ) u_msr (
        .clk        (clk),
        .rst_n      (rst_n),
        .bsp_strap  (bsp_strap),
        .msr_wr_en  (msr_wr_en),
        .msr_wr_data(msr_wr_data),
        .global_en  (global_en),
        .base_q     (base_q),
        .gdis_event (gdis_event),
        .msr_rd_data(msr_rd_data)
    );

    intc_win_decode #(.PADDR_W(PADDR_W)) u_dec (
        .mm_valid (mm_valid),
        .mm_write (mm_write),
        .mm_addr  (mm_addr),
        .mm_wdata (mm_wdata),
        .global_en(global_en),
        .base_q   (base_q),
        .mm_hit   (mm_hit),
        .acc      (acc)
    );

    // Soft reset of the window: INIT, a disabling write, or held while disabled
    assign wipe  = init_req | ~global_en | gdis_event;
    assign id_wr = slot_wr(acc, SLOT_ID);

    // ID and arbitration ID: loaded from the strap at power-up only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q  <= hw_id_strap;
            arb_q <= hw_id_strap;
        end else if (id_wr) begin
            id_q  <= acc.data[ID_LSB +: ID_W];
        end
    end

    // Next spurious-vector value; its enable bit drives the mask lock
    always_comb begin
        if (!rst_n || wipe)                svr_d = SVR_RESET;
        else if (slot_wr(acc, SLOT_SVR))   svr_d = acc.data[SVR_W-1:0];
        else                               svr_d = svr_q;
    end

    // Spurious-vector register
    always_ff @(posedge clk) begin
        svr_q <= svr_d;
    end

    // Control and setup registers: cleared by every reset flavour
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            tpr_q    <= '0;
            ldr_q    <= '0;
            dfr_q    <= '1;
            icr_lo_q <= '0;
            icr_hi_q <= '0;
            tinit_q  <= '0;
            tcur_q   <= '0;
            div_q    <= '0;
        end else begin
            if (slot_wr(acc, SLOT_TPR))   tpr_q    <= acc.data[7:0];
            if (slot_wr(acc, SLOT_LDR))   ldr_q    <= acc.data[31:24];
            if (slot_wr(acc, SLOT_DFR))   dfr_q    <= acc.data;
            if (slot_wr(acc, SLOT_ICRL))  icr_lo_q <= acc.data;
            if (slot_wr(acc, SLOT_ICRH))  icr_hi_q <= acc.data[31:24];
            if (slot_wr(acc, SLOT_TINIT)) tinit_q  <= acc.data;
            if (slot_wr(acc, SLOT_TCUR))  tcur_q   <= acc.data;
            if (slot_wr(acc, SLOT_DIV))   div_q    <= acc.data[3:0];
        end
    end

    intc_lvt_bank #(.N_LVT(N_LVT)) u_lvt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wipe      (wipe),
        .force_mask(~svr_d[SVR_EN_BIT]),
        .acc       (acc),
        .lvt_mask  (lvt_mask),
        .rd_data   (lvt_rd)
    );

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        intc_vec_bank #(
            .WORDS    (PEND_WORDS),
            .SLOT_BASE(BANK_SLOT[b])
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wipe   (wipe),
            .acc    (acc),
            .rd_data(bank_rd[b])
        );
    end

    // Read mux over the window slots
    always_comb begin
        rd_word = '0;
        case (acc.idx)
            SLOT_ID:    rd_word[ID_LSB +: ID_W] = id_q;
            SLOT_VER:   rd_word = VERSION;
            SLOT_TPR:   rd_word[7:0] = tpr_q;
            SLOT_LDR:   rd_word[31:24] = ldr_q;
            SLOT_DFR:   rd_word = dfr_q;
            SLOT_SVR:   rd_word[SVR_W-1:0] = svr_q;
            SLOT_ICRL:  rd_word = icr_lo_q;
            SLOT_ICRH:  rd_word[31:24] = icr_hi_q;
            SLOT_TINIT: rd_word = tinit_q;
            SLOT_TCUR:  rd_word = tcur_q;
            SLOT_DIV:   rd_word[3:0] = div_q;
            default: begin
                rd_word = lvt_rd;
                for (int b = 0; b < N_BANKS; b++) rd_word |= bank_rd[b];
            end
        endcase
    end

    // Outputs
    assign mm_rdata   = mm_hit ? rd_word : '0;
    assign ctl_enable = global_en & svr_q[SVR_EN_BIT];
    assign apic_id    = id_q;
    assign arb_id     = arb_q;
    assign tpr_level  = tpr_q;

    // R7: while globally disabled the window stays at its reset values
    a_r7_disabled_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !global_en |-> (tpr_q == '0 && svr_q == SVR_RESET && dfr_q == '1 && (&lvt_mask)));

    // R8: an INIT cycle restores the reset state of the window
    a_r8_init_restores: assert property (@(posedge clk) disable iff (!rst_n)
        init_req |=> (svr_q == SVR_RESET && tpr_q == '0 && (&lvt_mask) && !ctl_enable));

    // R8: an INIT cycle keeps the ID
    a_r8_init_keeps_id: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req && !id_wr) |=> $stable(apic_id));

endmodule

// File: tb/sim_intc_state_regs.sv
module sim_intc_state_regs;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 36;
    localparam logic [31:0] VER = 32'h0006_0014;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_req = 1'b0;
    logic [3:0] hw_id_strap = 4'hA;
    logic bsp_strap = 1'b1;
    logic msr_wr_en = 1'b0;
    logic [63:0] msr_wr_data = '0;
    logic [63:0] msr_rd_data;
    logic mm_valid = 1'b0, mm_write = 1'b0;
    logic [PW-1:0] mm_addr = '0;
    logic [31:0] mm_wdata = '0, mm_rdata;
    logic mm_hit, ctl_enable, global_en;
    logic [5:0] lvt_mask;
    logic [3:0] apic_id, arb_id;
    logic [7:0] tpr_level;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] data;
        logic        hit;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_state_regs #(.PADDR_W(PW), .ID_W(4), .N_LVT(6), .N_VEC(256), .VERSION(VER)) u0 (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .hw_id_strap(hw_id_strap),
        .bsp_strap(bsp_strap), .msr_wr_en(msr_wr_en), .msr_wr_data(msr_wr_data),
        .msr_rd_data(msr_rd_data), .mm_valid(mm_valid), .mm_write(mm_write),
        .mm_addr(mm_addr), .mm_wdata(mm_wdata), .mm_rdata(mm_rdata), .mm_hit(mm_hit),
        .ctl_enable(ctl_enable), .global_en(global_en), .lvt_mask(lvt_mask),
        .apic_id(apic_id), .arb_id(arb_id), .tpr_level(tpr_level)
    );

    function automatic void chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endfunction

    function automatic logic [PW-1:0] wa(input logic [23:0] base, input logic [11:0] off);
        return {base, off};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [PW-1:0] a, input logic [31:0] exp, input logic hit, input string tag);
        sb_item_t it;
        tick();
        mm_valid = 1'b1; mm_write = 1'b0; mm_addr = a;
        it.data = exp; it.hit = hit; it.tag = tag;
        sb_q.push_back(it);
        tick();
        mm_valid = 1'b0;
    endtask

    task automatic wr(input logic [PW-1:0] a, input logic [31:0] d);
        tick();
        mm_valid = 1'b1; mm_write = 1'b1; mm_addr = a; mm_wdata = d;
        tick();
        mm_valid = 1'b0; mm_write = 1'b0;
    endtask

    task automatic msr_wr(input logic [63:0] d);
        tick();
        msr_wr_en = 1'b1; msr_wr_data = d;
        tick();
        msr_wr_en = 1'b0;
    endtask

    // Monitor: compares every read against the head of the scoreboard
    always @(negedge clk) begin
        if (mm_valid && !mm_write) begin
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL monitor read with empty scoreboard actual %h expected none", mm_rdata);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                if (mm_rdata !== it.data || mm_hit !== it.hit) begin
                    errors++;
                    $display("FAIL %s actual hit=%b data=%h expected hit=%b data=%h",
                             it.tag, mm_hit, mm_rdata, it.hit, it.data);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    localparam logic [23:0] B0 = 24'hFEE00;
    localparam logic [23:0] B1 = 24'h12345;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(msr_rd_data, 64'h0000_0000_FEE0_0900, "R1 base/enable after reset");
        chk({63'b0, ctl_enable}, 64'd0, "R2 disabled after reset");
        chk({58'b0, lvt_mask}, 64'h3F, "R2 masks after reset");
        chk({56'b0, arb_id, apic_id}, 64'hAA, "R3 strap id on ports");

        rd(wa(B0, 12'h020), 32'h0A00_0000, 1'b1, "R3 id readback");
        rd(wa(B0, 12'h030), VER, 1'b1, "R12 version");
        rd(wa(B0, 12'h080), 32'h0, 1'b1, "R2 tpr");
        rd(wa(B0, 12'h0D0), 32'h0, 1'b1, "R2 ldr");
        rd(wa(B0, 12'h0E0), 32'hFFFF_FFFF, 1'b1, "R2 dfr");
        rd(wa(B0, 12'h0F0), 32'h0000_00FF, 1'b1, "R2 svr");
        rd(wa(B0, 12'h320), 32'h0001_0000, 1'b1, "R2 lvt0");
        rd(wa(B0, 12'h370), 32'h0001_0000, 1'b1, "R2 lvt5");
        rd(wa(B0, 12'h1F0), 32'h0, 1'b1, "R2 trigger word7");
        rd(wa(B0, 12'h300), 32'h0, 1'b1, "R2 icr low");
        rd(wa(B0, 12'h390), 32'h0, 1'b1, "R2 timer current");
        rd(wa(B0, 12'h3E0), 32'h0, 1'b1, "R2 divide");
        rd(wa(B0, 12'h024), 32'h0, 1'b0, "R5 misaligned not claimed");

        wr(wa(B0, 12'h020), 32'hFF00_0000);
        rd(wa(B0, 12'h020), 32'h0F00_0000, 1'b1, "R4 narrow id masking");

        msr_wr(64'hFFFF_FFF0_FEE0_0EFF);
        @(negedge clk);
        chk(msr_rd_data, 64'h0000_0000_FEE0_0900, "R6 bsp and reserved bits");

        wr(wa(B0, 12'h0F0), 32'h0000_01FF);
        @(negedge clk);
        chk({63'b0, ctl_enable}, 64'd1, "R9 software enable");
        wr(wa(B0, 12'h320), 32'h0000_0041);
        wr(wa(B0, 12'h370), 32'h0000_0052);
        @(negedge clk);
        chk({58'b0, lvt_mask}, 64'h1E, "R10 unmask allowed when enabled");
        wr(wa(B0, 12'h210), 32'h1234_5678);
        wr(wa(B0, 12'h100), 32'h8000_0001);
        wr(wa(B0, 12'h080), 32'h0000_0020);

        wr(wa(B0, 12'h0F0), 32'h0000_00FF);
        @(negedge clk);
        chk({63'b0, ctl_enable}, 64'd0, "R9 software disable");
        chk({58'b0, lvt_mask}, 64'h3F, "R10 all masks forced");
        rd(wa(B0, 12'h320), 32'h0001_0041, 1'b1, "R10 lvt0 forced mask");
        wr(wa(B0, 12'h370), 32'h0000_0033);
        rd(wa(B0, 12'h370), 32'h0001_0033, 1'b1, "R10 unmask write ignored");
        rd(wa(B0, 12'h210), 32'h1234_5678, 1'b1, "R11 pending kept");
        rd(wa(B0, 12'h100), 32'h8000_0001, 1'b1, "R11 in-service kept");
        rd(wa(B0, 12'h080), 32'h0000_0020, 1'b1, "R11 tpr kept");

        wr(wa(B0, 12'h0F0), 32'h0000_01FF);
        @(negedge clk);
        chk({63'b0, ctl_enable}, 64'd1, "R9 re-enable");
        wr(wa(B0, 12'h320), 32'h0000_0033);
        @(negedge clk);
        chk({58'b0, lvt_mask}, 64'h3E, "R9 unmask after re-enable");

        msr_wr(64'h0000_0000_1234_5800);
        @(negedge clk);
        chk(msr_rd_data, 64'h0000_0000_1234_5900, "R5 relocated base");
        rd(wa(B0, 12'h020), 32'h0, 1'b0, "R5 old window not claimed");
        wr(wa(B0, 12'h080), 32'h0000_0077);
        rd(wa(B1, 12'h080), 32'h0000_0020, 1'b1, "R5 unclaimed write ignored");
        rd(wa(B1, 12'h020), 32'h0F00_0000, 1'b1, "R5 new window claimed");
        wr(wa(B1, 12'h030), 32'hFFFF_FFFF);
        rd(wa(B1, 12'h030), VER, 1'b1, "R12 version write ignored");

        tick();
        init_req = 1'b1;
        tick();
        init_req = 1'b0;
        @(negedge clk);
        chk(msr_rd_data, 64'h0000_0000_1234_5900, "R8 base/enable kept");
        chk({56'b0, arb_id, apic_id}, 64'hAF, "R8 ids kept");
        chk({63'b0, ctl_enable}, 64'd0, "R8 disabled after init");
        rd(wa(B1, 12'h020), 32'h0F00_0000, 1'b1, "R8 id kept");
        rd(wa(B1, 12'h080), 32'h0, 1'b1, "R8 tpr cleared");
        rd(wa(B1, 12'h0F0), 32'h0000_00FF, 1'b1, "R8 svr reset");
        rd(wa(B1, 12'h320), 32'h0001_0000, 1'b1, "R8 lvt reset");
        rd(wa(B1, 12'h210), 32'h0, 1'b1, "R8 pending cleared");
        rd(wa(B1, 12'h0E0), 32'hFFFF_FFFF, 1'b1, "R8 dfr reset");
        rd(wa(B1, 12'h030), VER, 1'b1, "R12 version after init");

        wr(wa(B1, 12'h080), 32'h0000_0044);
        wr(wa(B1, 12'h0F0), 32'h0000_01FF);
        wr(wa(B1, 12'h020), 32'h0300_0000);
        msr_wr(64'h0000_0000_1234_5000);
        @(negedge clk);
        chk(msr_rd_data, 64'h0000_0000_1234_5100, "R7 global enable cleared");
        chk({63'b0, ctl_enable}, 64'd0, "R7 effective enable off");
        chk({58'b0, lvt_mask}, 64'h3F, "R7 masks reset");
        rd(wa(B1, 12'h080), 32'h0, 1'b0, "R7 no claim while disabled");
        wr(wa(B1, 12'h0F0), 32'h0000_01FF);
        msr_wr(64'h0000_0000_1234_5800);
        rd(wa(B1, 12'h080), 32'h0, 1'b1, "R7 tpr back to reset");
        rd(wa(B1, 12'h0F0), 32'h0000_00FF, 1'b1, "R7 svr back to reset");
        rd(wa(B1, 12'h020), 32'h0300_0000, 1'b1, "R7 id kept");
        rd(wa(B1, 12'h030), VER, 1'b1, "R12 version after disable");
        @(negedge clk);
        chk({63'b0, ctl_enable}, 64'd0, "R9 needs software enable");

        tick();
        rst_n = 1'b0; hw_id_strap = 4'h5; bsp_strap = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        @(negedge clk);
        chk(msr_rd_data, 64'h0000_0000_FEE0_0800, "R1 second reset base and strap");
        chk({56'b0, arb_id, apic_id}, 64'h55, "R3 new strap id");
        rd(wa(B0, 12'h020), 32'h0500_0000, 1'b1, "R3 id readback after reset");

        tick();
        tick();
        if (sb_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard all requirements actual %0d pending expected 0", sb_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule